// File: doc/BRIEF.md
# Multi-Port Cell Receive Interface

This block is the PHY-side receive half of an 8-bit, four-port cell bus in the style of UTOPIA Level 1. Each port has a small receive FIFO that holds whole 53-byte cells. Each port also has its own cell-ready flag toward the ATM-layer device, and that device has its own active-low enable for each port. When the device pulls a port's enable low, the block sends the next byte of that port's cell one clock later. The byte comes with a valid strobe, a start-of-cell marker on the first byte and an odd parity bit. All timing comes from one free-running receive clock.

The FIFOs are loaded through a valid/ready byte port that carries a port number. A byte is taken on a clock edge where `fill_valid` and `fill_ready` are both high. `fill_ready` drops while the addressed port's FIFO is full, and the source must then hold the byte. On the output side the enables are the back-pressure. A byte leaves only in a cycle where the serving port's enable is low, and a cell pauses for as long as that enable stays high. A configuration input chooses whether the data bus and the start-of-cell line float while no enable is low.

Top module: `cellbus_rx`

## Requirements
- R1: `rx_clav[i]` is high only while port i's FIFO holds at least one complete cell that has not yet started out. It rises the cycle after the 53rd byte of a cell is written. It drops the cycle after the first byte of the last such cell is taken, unless another complete cell is waiting.
- R2: After reset, `rx_clav`, `rx_vld` and `rx_multi` are low and `fill_ready` is high.
- R3: With no cell in progress, a low `rx_en_n[i]` on a port whose `rx_clav[i]` is high starts a transfer. Each transferred byte appears on `rx_data` with `rx_vld` high one clock after the edge that sampled the enable, in the order the bytes were written. An enable on a port with no complete cell transfers nothing.
- R4: `rx_soc` is high together with the first byte of every cell and low with the other 52 bytes.
- R5: `rx_par` is odd parity over `rx_data`, so the nine bits together have an odd number of ones.
- R6: The byte position within a cell advances only on edges where the serving port's enable is low. Cycles with that enable high produce no `rx_vld` and lose no byte.
- R7: Enable bit i belongs to port i. When more than one enable is low and no cell is in progress, the lowest-numbered low enable picks the port. `rx_multi` is high in the cycle after any edge at which two or more enables were low.
- R8: Once a cell has started, it stays with its port until byte 53. Enables of other ports are ignored during that time, and a low enable on another port alone transfers nothing.
- R9: `rx_oe` is low only when `cfg_hiz` is 1 and all four enables are high. While `rx_oe` is low, `rx_data` and `rx_soc` are high impedance.
- R10: `fill_ready` is low while the FIFO selected by `fill_port` is full. A byte offered then is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hiz | input | 1 | 1: float data and start-of-cell while no enable is low |
| fill_valid | input | 1 | Fill byte offered |
| fill_ready | output | 1 | Addressed FIFO can take a byte |
| fill_port | input | 2 | Port whose FIFO the fill byte goes to |
| fill_data | input | 8 | Fill byte |
| rx_en_n | input | 4 | Per-port active-low enable from the ATM layer |
| rx_clav | output | 4 | Per-port complete-cell-waiting flag |
| rx_data | output | 8 | Cell byte, tri-stateable |
| rx_soc | output | 1 | First byte of cell, tri-stateable |
| rx_par | output | 1 | Odd parity over rx_data |
| rx_vld | output | 1 | rx_data carries a new byte this cycle |
| rx_oe | output | 1 | Data and start-of-cell are driven |
| rx_multi | output | 1 | Two or more enables were low at the last edge |

## Verification
The bench first pulls whole cells with the enable held low. It then pulls cells with gaps of enable-high cycles, which separates a counter that advances on every clock from one that advances only on enabled edges. Part way into a cell, it lowers a foreign port's enable, both alone and together with the serving port's enable. This shows whether the cell stays with its port or moves over. With no cell in progress, it lowers two enables at once, which checks that the lowest-numbered port is chosen. It also writes to a full FIFO and then drains it, to show that the refused byte never comes out.

// File: rtl/cellbus_pkg.sv
package cellbus_pkg;
  localparam int PORTS_DEF      = 4;
  localparam int DW_DEF         = 8;
  localparam int CELL_BYTES_DEF = 53;
  localparam int CELLS_DEF      = 2;
endpackage

// File: rtl/cell_fifo.sv
module cell_fifo #(
  parameter int DW         = 8,
  parameter int CELL_BYTES = 53,
  parameter int CELLS      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_rdy,
  input  logic          rd_en,
  input  logic          take,
  output logic [DW-1:0] rd_data,
  output logic          clav
);
  localparam int DEPTH = CELL_BYTES * CELLS;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(CELLS + 1);
  localparam int BW    = $clog2(CELL_BYTES);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic [BW-1:0] wbyte_q;
  logic [CW-1:0] cells_q;
  logic          wr_ok, done;

  assign wr_rdy  = (cnt_q != (AW+1)'(DEPTH));
  assign wr_ok   = wr_en && wr_rdy;
  assign done    = wr_ok && (wbyte_q == BW'(CELL_BYTES - 1));
  assign rd_data = mem[rp_q];
  assign clav    = (cells_q != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      wbyte_q <= '0;
      cells_q <= '0;
    end else begin
      if (wr_ok) begin
        wp_q    <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
        wbyte_q <= done ? '0 : wbyte_q + 1'b1;
      end
      if (rd_en) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({wr_ok, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      case ({done, take})
        2'b10:   cells_q <= cells_q + 1'b1;
        2'b01:   cells_q <= cells_q - 1'b1;
        default: cells_q <= cells_q;
      endcase
    end
  end
endmodule

// File: rtl/cell_arb.sv
module cell_arb #(
  parameter int PORTS      = 4,
  parameter int CELL_BYTES = 53
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PORTS-1:0]         en_n,
  input  logic [PORTS-1:0]         clav,
  output logic                     go,
  output logic                     first,
  output logic [$clog2(PORTS)-1:0] sel,
  output logic [PORTS-1:0]         rd_en,
  output logic [PORTS-1:0]         take,
  output logic                     multi
);
  localparam int SW = $clog2(PORTS);
  localparam int BW = $clog2(CELL_BYTES);

  logic          busy_q;
  logic [SW-1:0] port_q, low_idx;
  logic [BW-1:0] bcnt_q;
  logic [PORTS-1:0] low;
  logic          found;

  always_comb begin
    low     = ~en_n;
    low_idx = '0;
    found   = 1'b0;
    for (int i = PORTS - 1; i >= 0; i--) begin
      if (low[i]) begin
        low_idx = SW'(i);
        found   = 1'b1;
      end
    end
    if (busy_q) begin
      sel = port_q;
      go  = low[port_q];
    end else begin
      sel = low_idx;
      go  = found && clav[low_idx];
    end
    first = go && !busy_q;
    for (int i = 0; i < PORTS; i++) begin
      rd_en[i] = go && (sel == SW'(i));
      take[i]  = rd_en[i] && !busy_q;
    end
    multi = ($countones(low) > 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      port_q <= '0;
      bcnt_q <= '0;
    end else if (go) begin
      port_q <= sel;
      if (bcnt_q == BW'(CELL_BYTES - 1)) begin
        busy_q <= 1'b0;
        bcnt_q <= '0;
      end else begin
        busy_q <= 1'b1;
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cellbus_rx.sv
module cellbus_rx
  import cellbus_pkg::*;
#(
  parameter int PORTS      = PORTS_DEF,
  parameter int DW         = DW_DEF,
  parameter int CELL_BYTES = CELL_BYTES_DEF,
  parameter int CELLS      = CELLS_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_hiz,
  input  logic                     fill_valid,
  output logic                     fill_ready,
  input  logic [$clog2(PORTS)-1:0] fill_port,
  input  logic [DW-1:0]            fill_data,
  input  logic [PORTS-1:0]         rx_en_n,
  output logic [PORTS-1:0]         rx_clav,
  output logic [DW-1:0]            rx_data,
  output logic                     rx_soc,
  output logic                     rx_par,
  output logic                     rx_vld,
  output logic                     rx_oe,
  output logic                     rx_multi
);
  localparam int SW = $clog2(PORTS);

  logic [DW-1:0]    fifo_q [PORTS];
  logic [PORTS-1:0] wr_rdy, rd_en, take;
  logic             go, first, multi;
  logic [SW-1:0]    sel;
  logic [DW-1:0]    data_q;
  logic             soc_q, vld_q, multi_q;

  for (genvar g = 0; g < PORTS; g++) begin : g_port
    cell_fifo #(
      .DW(DW), .CELL_BYTES(CELL_BYTES), .CELLS(CELLS)
    ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fill_valid && (fill_port == SW'(g))),
      .wr_data (fill_data),
      .wr_rdy  (wr_rdy[g]),
      .rd_en   (rd_en[g]),
      .take    (take[g]),
      .rd_data (fifo_q[g]),
      .clav    (rx_clav[g])
    );
  end

  cell_arb #(.PORTS(PORTS), .CELL_BYTES(CELL_BYTES)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .en_n  (rx_en_n),
    .clav  (rx_clav),
    .go    (go),
    .first (first),
    .sel   (sel),
    .rd_en (rd_en),
    .take  (take),
    .multi (multi)
  );

  assign fill_ready = wr_rdy[fill_port];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      soc_q   <= 1'b0;
      vld_q   <= 1'b0;
      multi_q <= 1'b0;
    end else begin
      vld_q   <= go;
      soc_q   <= first;
      multi_q <= multi;
      if (go) data_q <= fifo_q[sel];
    end
  end

  assign rx_oe    = !cfg_hiz || (rx_en_n != '1);
  assign rx_data  = rx_oe ? data_q : 'z;
  assign rx_soc   = rx_oe ? soc_q : 1'bz;
  assign rx_par   = ~^data_q;
  assign rx_vld   = vld_q;
  assign rx_multi = multi_q;
endmodule

// File: rtl/cellbus_rx_chk.sv
module cellbus_rx_chk #(
  parameter int PORTS      = 4,
  parameter int CELL_BYTES = 53
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PORTS-1:0] en_n,
  input logic [PORTS-1:0] clav,
  input logic             vld,
  input logic             soc,
  input logic             multi,
  input logic             oe
);
  localparam int BW = $clog2(CELL_BYTES);
  logic [BW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= '0;
    else if (vld) pos_q <= (pos_q == BW'(CELL_BYTES - 1)) ? '0 : pos_q + 1'b1;
  end

  // R4
  soc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && pos_q == '0) |-> soc);
  // R4
  soc_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && pos_q != '0) |-> !soc);
  // R6
  vld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $past(en_n != '1));
  // R3
  soc_clav_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soc |-> $past((~en_n & clav) != '0));
  // R7
  multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~en_n) > 1) |=> multi);
  // R9
  oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n != '1) |-> oe);
endmodule

bind cellbus_rx cellbus_rx_chk #(.PORTS(PORTS), .CELL_BYTES(CELL_BYTES)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en_n  (rx_en_n),
  .clav  (rx_clav),
  .vld   (vld_q),
  .soc   (soc_q),
  .multi (multi_q),
  .oe    (rx_oe)
);

// File: tb/cellbus_rx_test.sv
`timescale 1ns/1ps
module cellbus_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_hiz = 1'b0;
  logic       fill_valid = 1'b0;
  logic [1:0] fill_port = '0;
  logic [7:0] fill_data = '0;
  logic [3:0] rx_en_n = 4'hF;
  logic       fill_ready;
  logic [3:0] rx_clav;
  wire  [7:0] rx_data;
  wire        rx_soc;
  logic       rx_par, rx_vld, rx_oe, rx_multi;

  cellbus_rx uut (
    .clk(clk), .rst_n(rst_n), .cfg_hiz(cfg_hiz),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_port(fill_port), .fill_data(fill_data),
    .rx_en_n(rx_en_n), .rx_clav(rx_clav), .rx_data(rx_data),
    .rx_soc(rx_soc), .rx_par(rx_par), .rx_vld(rx_vld),
    .rx_oe(rx_oe), .rx_multi(rx_multi)
  );

  always #10 clk = ~clk;

  typedef struct { logic [7:0] d; logic s; int due; } exp_t;
  exp_t       eq[$];
  logic [7:0] mq[4][$];
  int         mcells[4];
  int         wcnt[4];
  int         mbusy = 0, mport = 0, mpos = 0;
  int         cyc = 0;
  int         checks = 0, fails = 0;
  bit         run = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare produced bytes against the scoreboard (R3, R4, R5)
  always @(negedge clk) begin
    if (run) begin
      if (eq.size() > 0 && eq[0].due == cyc) begin
        chk(rx_vld == 1'b1, "R3 vld", int'(rx_vld), 1);
        chk(rx_data == eq[0].d, "R3 data", int'(rx_data), int'(eq[0].d));
        chk(rx_soc == eq[0].s, "R4 soc", int'(rx_soc), int'(eq[0].s));
        chk(^{rx_data, rx_par} == 1'b1, "R5 parity", int'(rx_par), int'(~^rx_data));
        void'(eq.pop_front());
      end else if (rx_vld) begin
        chk(1'b0, "R6 unexpected vld", 1, 0);
      end
    end
  end

  task automatic fill_byte(input int p, input logic [7:0] d);
    fill_port  = 2'(p);
    fill_data  = d;
    fill_valid = 1'b1;
    #1;
    if (fill_ready) begin
      mq[p].push_back(d);
      wcnt[p]++;
      if (wcnt[p] % 53 == 0) mcells[p]++;
    end
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic fill_cell(input int p, input logic [7:0] seed);
    for (int i = 0; i < 53; i++) fill_byte(p, seed + 8'(i));
  endtask

  task automatic step(input logic [3:0] en);
    logic [3:0] low;
    int sel;
    bit go;
    rx_en_n = en;
    low = ~en;
    go = 0;
    sel = 0;
    if (mbusy != 0) begin
      sel = mport;
      go = low[sel];
    end else begin
      for (int i = 3; i >= 0; i--) if (low[i]) sel = i;
      go = (low != 0) && (mcells[sel] > 0);
    end
    if (go) begin
      exp_t e;
      e.d = mq[sel].pop_front();
      e.s = (mbusy == 0);
      e.due = cyc + 1;
      eq.push_back(e);
      if (mbusy == 0) mcells[sel]--;
      mport = sel;
      if (mpos == 52) begin mbusy = 0; mpos = 0; end
      else begin mbusy = 1; mpos++; end
    end
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1;
    // R2 reset state
    chk(rx_clav == 4'h0, "R2 clav", int'(rx_clav), 0);
    chk(rx_vld == 1'b0, "R2 vld", int'(rx_vld), 0);
    chk(rx_multi == 1'b0, "R2 multi", int'(rx_multi), 0);
    chk(fill_ready == 1'b1, "R2 fill_ready", int'(fill_ready), 1);

    // R1 partial cell does not raise the flag
    for (int i = 0; i < 52; i++) fill_byte(0, 8'h10 + 8'(i));
    chk(rx_clav[0] == 1'b0, "R1 partial", int'(rx_clav[0]), 0);
    fill_byte(0, 8'h10 + 8'd52);
    chk(rx_clav[0] == 1'b1, "R1 complete", int'(rx_clav[0]), 1);

    fill_cell(1, 8'h40);
    fill_cell(2, 8'h80);
    fill_cell(3, 8'hC0);
    fill_cell(3, 8'h21);
    // R10 full FIFO refuses a byte
    fill_port = 2'd3;
    #1;
    chk(fill_ready == 1'b0, "R10 full", int'(fill_ready), 0);
    fill_byte(3, 8'hEE);
    chk(rx_clav == 4'hF, "R1 all ports", int'(rx_clav), 4'hF);

    // R6 port 2 with pauses; R1 flag drops once the cell starts
    step(4'b1011);
    chk(rx_clav[2] == 1'b0, "R1 taken", int'(rx_clav[2]), 0);
    for (int i = 1; i < 53; i++) begin
      if (i % 17 == 0) begin step(4'hF); step(4'hF); end
      step(4'b1011);
    end
    step(4'hF);

    // R8 port 1 keeps its cell against foreign enables
    for (int i = 0; i < 5; i++) step(4'b1101);
    step(4'b1110);
    step(4'b1100);
    chk(rx_multi == 1'b1, "R7 multi flag", int'(rx_multi), 1);
    while (mbusy != 0) step(4'b1101);
    step(4'hF);
    chk(rx_multi == 1'b0, "R7 multi clear", int'(rx_multi), 0);

    // R7 lowest-numbered port wins when idle
    step(4'b0110);
    chk(rx_clav[0] == 1'b0, "R7 port0 served", int'(rx_clav[0]), 0);
    chk(rx_clav[3] == 1'b1, "R7 port3 waits", int'(rx_clav[3]), 1);
    while (mbusy != 0) step(4'b0110);

    // port 3 drains two cells; refused byte must not appear (R10)
    while (mbusy != 0 || mcells[3] > 0) step(4'b0111);
    fill_port = 2'd3;
    #1;
    chk(fill_ready == 1'b1, "R10 room again", int'(fill_ready), 1);
    chk(rx_clav == 4'h0, "R1 drained", int'(rx_clav), 0);

    // R3 enable on an empty port transfers nothing
    step(4'b1110);
    step(4'hF);
    step(4'hF);
    chk(eq.size() == 0, "R3 scoreboard empty", eq.size(), 0);

    // R9 bus drive control
    cfg_hiz = 1'b1;
    rx_en_n = 4'hF;
    #1;
    chk(rx_oe == 1'b0, "R9 float", int'(rx_oe), 0);
    rx_en_n = 4'b1110;
    #1;
    chk(rx_oe == 1'b1, "R9 enabled drive", int'(rx_oe), 1);
    cfg_hiz = 1'b0;
    rx_en_n = 4'hF;
    #1;
    chk(rx_oe == 1'b1, "R9 always drive", int'(rx_oe), 1);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule